// File: doc/BRIEF.md
# Character-Clocked Raster Address Generator

This block is the timing core of a character-based video display controller. On every clock, which is one character cell, it presents a 14-bit memory address and a 5-bit raster-line number for the cell being painted, together with a display-enable window and horizontal and vertical sync pulses. Software programs its geometry through an indexed register file: it first writes a register index to the select port, then writes the value through the data port.

The address sequence is not derived from a multiplier. A running address advances by one per character, and a line-start latch holds the address at which the next character row begins. The latch is loaded only when the character counter exactly equals the displayed-width register on the last raster line of a row, and every raster-line wrap reloads the running address from it. Unusual settings therefore give repeatable glitches. The clearest is a displayed width larger than the line length: the latch never moves, so every row shows the same addresses. A build parameter selects a variant in which the horizontal sync is suppressed entirely when the sync window runs past the line length.

Register indices: 0 line length minus one, 1 displayed characters, 2 hsync start, 3 sync widths (bits 3:0 horizontal, bits 7:4 vertical), 4 rows per frame minus one, 6 displayed rows, 7 vsync row, 9 last raster line of a row, 12 start address high (6 bits), 13 start address low. All other indices are unmapped.

Top module: `crtc_raster_gen`

## Requirements
- R1: Within a line, apart from the line-wrap clock, `mem_addr` increases by exactly one (modulo 2^14) on every clock.
- R2: The character counter counts 0 up to the value of index 0 and then returns to 0, so one raster line lasts (index 0 + 1) clocks.
- R3: On a clock where the character counter equals index 1 and the raster counter equals index 9, the current `mem_addr` is captured into the line-start latch; the latch changes at no other time except at frame start.
- R4: On each line wrap the raster counter (`row_addr`) steps up by one, or returns to 0 and the row counter steps up if it equalled index 9; in both cases `mem_addr` reloads from the line-start latch (including a capture made on that same clock).
- R5: When the row counter equals index 4 and the raster counter wraps, both `mem_addr` and the line-start latch load the start address {index 12[5:0], index 13}.
- R6: If index 1 is greater than index 0, the latch is never loaded during the frame and every raster line of every row starts at the start address.
- R7: `hsync` is high while the character counter c satisfies index2 <= c < index2 + index3[3:0]; a width of 0 gives no pulse.
- R8: With SYNC_QUIRK=1, when index2 + index3[3:0] exceeds index 0, `hsync` stays low; with SYNC_QUIRK=0 the window of R7 applies unchanged.
- R9: `vsync` rises at raster 0 of row index 7 and lasts index3[7:4] raster lines, a value of 0 meaning 16; it ends at the latest at frame wrap.
- R10: `disp_en` is high exactly when the character counter is below index 1 and the row counter is below index 6.
- R11: A data write goes to the index last written to the select port and affects outputs from the next clock; writes to unmapped indices change nothing.
- R12: After reset all counters are 0, `mem_addr` equals the reset start address 0x3000, and the registers hold 63, 40, 46, 0x8E, 38, 25, 30, 7 for indices 0, 1, 2, 3, 4, 6, 7, 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Strobe: load the register index |
| sel_data | input | 5 | Register index |
| dat_we | input | 1 | Strobe: write the selected register |
| dat_data | input | 8 | Register value |
| mem_addr | output | 14 | Memory address of the current cell |
| row_addr | output | 5 | Raster line within the character row |
| disp_en | output | 1 | Display-enable window |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
All five outputs are combinational decodes of registered counters, so each result of a clock edge is due at that edge and is sampled half a period later, at the falling edge; a register write issued before an edge is reflected in the outputs from that same edge onward, one clock after the data strobe. The reference model advances once per rising edge using the register values held before the edge and applies writes afterwards, which gives exactly this one-clock latency, and it is compared with both variants on every falling edge. Directed phases drive the corner cases: the latch captured on the wrap clock itself, a displayed width beyond the line length, a sync window past the line end, a zero sync width, a vertical width of 16 that outlasts the frame, and writes to unmapped indices.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int unsigned HCW = 8;   // character counter width
  parameter int unsigned RAW = 5;   // raster counter width
  parameter int unsigned VRW = 7;   // row counter width
  parameter int unsigned MAW = 14;  // memory address width
  parameter int unsigned SWW = 4;   // sync width field
  parameter int unsigned IXW = 5;   // register index width

  typedef struct packed {
    logic [HCW-1:0] h_total;
    logic [HCW-1:0] h_disp;
    logic [HCW-1:0] hs_pos;
    logic [SWW-1:0] vs_wid;
    logic [SWW-1:0] hs_wid;
    logic [VRW-1:0] v_total;
    logic [VRW-1:0] v_disp;
    logic [VRW-1:0] vs_row;
    logic [RAW-1:0] ras_max;
    logic [MAW-1:0] base;
  } crtc_cfg_t;

  // end of the hsync window, one bit wider than the counter
  function automatic logic [HCW:0] hs_end(input logic [HCW-1:0] pos,
                                          input logic [SWW-1:0] wid);
    return {1'b0, pos} + {{(HCW+1-SWW){1'b0}}, wid};
  endfunction

  function automatic logic hs_window(input logic [HCW-1:0] cnt,
                                     input logic [HCW-1:0] pos,
                                     input logic [SWW-1:0] wid);
    return (cnt >= pos) && ({1'b0, cnt} < hs_end(pos, wid));
  endfunction

  function automatic logic hs_overrun(input logic [HCW-1:0] pos,
                                      input logic [SWW-1:0] wid,
                                      input logic [HCW-1:0] total);
    return hs_end(pos, wid) > {1'b0, total};
  endfunction

  // raster lines elapsed since vsync row start, compared with the width
  function automatic logic vs_window(input logic [VRW-1:0] row,
                                     input logic [RAW-1:0] ras,
                                     input logic [VRW-1:0] vs_row,
                                     input logic [RAW-1:0] ras_max,
                                     input logic [SWW-1:0] wid);
    logic [15:0] lines;
    logic [15:0] span;
    span  = (wid == '0) ? 16'(1 << SWW) : 16'(wid);
    lines = 16'(row - vs_row) * (16'(ras_max) + 16'd1) + 16'(ras);
    return (row >= vs_row) && (lines < span);
  endfunction
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter logic [7:0] RST_HTOT  = 8'd63,
  parameter logic [7:0] RST_HDISP = 8'd40,
  parameter logic [7:0] RST_HSPOS = 8'd46,
  parameter logic [7:0] RST_WIDS  = 8'h8E,
  parameter logic [7:0] RST_VTOT  = 8'd38,
  parameter logic [7:0] RST_VDISP = 8'd25,
  parameter logic [7:0] RST_VSROW = 8'd30,
  parameter logic [7:0] RST_RMAX  = 8'd7,
  parameter logic [MAW-1:0] RST_BASE = 14'h3000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_we,
  input  logic [IXW-1:0] sel_data,
  input  logic           dat_we,
  input  logic [7:0]     dat_data,
  output crtc_cfg_t      cfg,
  output logic           sync_ovr
);
  localparam logic [IXW-1:0] IX_HTOT  = IXW'(0);
  localparam logic [IXW-1:0] IX_HDISP = IXW'(1);
  localparam logic [IXW-1:0] IX_HSPOS = IXW'(2);
  localparam logic [IXW-1:0] IX_WIDS  = IXW'(3);
  localparam logic [IXW-1:0] IX_VTOT  = IXW'(4);
  localparam logic [IXW-1:0] IX_VDISP = IXW'(6);
  localparam logic [IXW-1:0] IX_VSROW = IXW'(7);
  localparam logic [IXW-1:0] IX_RMAX  = IXW'(9);
  localparam logic [IXW-1:0] IX_BHI   = IXW'(12);
  localparam logic [IXW-1:0] IX_BLO   = IXW'(13);
  localparam int unsigned    BHW      = MAW - 8;

  logic [IXW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (sel_we) idx_q <= sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.h_total <= RST_HTOT[HCW-1:0];
      cfg.h_disp  <= RST_HDISP[HCW-1:0];
      cfg.hs_pos  <= RST_HSPOS[HCW-1:0];
      cfg.vs_wid  <= RST_WIDS[7:4];
      cfg.hs_wid  <= RST_WIDS[3:0];
      cfg.v_total <= RST_VTOT[VRW-1:0];
      cfg.v_disp  <= RST_VDISP[VRW-1:0];
      cfg.vs_row  <= RST_VSROW[VRW-1:0];
      cfg.ras_max <= RST_RMAX[RAW-1:0];
      cfg.base    <= RST_BASE;
    end else if (dat_we) begin
      case (idx_q)
        IX_HTOT:  cfg.h_total <= dat_data[HCW-1:0];
        IX_HDISP: cfg.h_disp  <= dat_data[HCW-1:0];
        IX_HSPOS: cfg.hs_pos  <= dat_data[HCW-1:0];
        IX_WIDS:  begin
          cfg.vs_wid <= dat_data[7:4];
          cfg.hs_wid <= dat_data[3:0];
        end
        IX_VTOT:  cfg.v_total <= dat_data[VRW-1:0];
        IX_VDISP: cfg.v_disp  <= dat_data[VRW-1:0];
        IX_VSROW: cfg.vs_row  <= dat_data[VRW-1:0];
        IX_RMAX:  cfg.ras_max <= dat_data[RAW-1:0];
        IX_BHI:   cfg.base[MAW-1:8] <= dat_data[BHW-1:0];
        IX_BLO:   cfg.base[7:0]     <= dat_data;
        default:  ;
      endcase
    end
  end

  assign sync_ovr = hs_overrun(cfg.hs_pos, cfg.hs_wid, cfg.h_total);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(cfg));
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount
  import crtc_pkg::*;
#(
  parameter bit SYNC_QUIRK = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] h_total,
  input  logic [HCW-1:0] h_disp,
  input  logic [HCW-1:0] hs_pos,
  input  logic [SWW-1:0] hs_wid,
  input  logic           sync_ovr,
  output logic [HCW-1:0] hcnt,
  output logic           h_wrap,
  output logic           h_act,
  output logic           hsync
);
  assign h_wrap = (hcnt == h_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else if (h_wrap) hcnt <= '0;
    else hcnt <= hcnt + 1'b1;
  end

  assign h_act = (hcnt < h_disp);

  logic in_win;
  assign in_win = hs_window(hcnt, hs_pos, hs_wid);

  generate
    if (SYNC_QUIRK) begin : g_quirk
      assign hsync = in_win && !sync_ovr;
    end else begin : g_plain
      assign hsync = in_win;
    end
  endgenerate

  // R2
  hwrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (hcnt == '0));
  // R7
  hsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (hcnt >= hs_pos));
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_wrap,
  input  logic [RAW-1:0] ras_max,
  input  logic [VRW-1:0] v_total,
  input  logic [VRW-1:0] v_disp,
  input  logic [VRW-1:0] vs_row,
  input  logic [SWW-1:0] vs_wid,
  output logic [RAW-1:0] rcnt,
  output logic [VRW-1:0] vrow,
  output logic           row_end,
  output logic           frame_wrap,
  output logic           v_act,
  output logic           vsync
);
  assign row_end    = (rcnt == ras_max);
  assign frame_wrap = h_wrap && row_end && (vrow == v_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      vrow <= '0;
    end else if (h_wrap) begin
      if (row_end) begin
        rcnt <= '0;
        vrow <= (vrow == v_total) ? '0 : vrow + 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  assign v_act = (vrow < v_disp);
  assign vsync = vs_window(vrow, rcnt, vs_row, ras_max, vs_wid);

  // R4
  ras_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && !row_end) |=> (rcnt == $past(rcnt) + 1'b1));
  // R4
  ras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> ($stable(rcnt) && $stable(vrow)));
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
  import crtc_pkg::*;
#(
  parameter logic [MAW-1:0] RST_BASE = 14'h3000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_wrap,
  input  logic           latch_hit,
  input  logic           frame_wrap,
  input  logic [MAW-1:0] base,
  output logic [MAW-1:0] ma,
  output logic [MAW-1:0] line_start
);
  logic [MAW-1:0] start_nxt;
  assign start_nxt = latch_hit ? ma : line_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma         <= RST_BASE;
      line_start <= RST_BASE;
    end else if (frame_wrap) begin
      ma         <= base;
      line_start <= base;
    end else begin
      line_start <= start_nxt;
      ma         <= h_wrap ? start_nxt : ma + 1'b1;
    end
  end

  // R1
  ma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> (ma == MAW'($past(ma) + 1'b1)));
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_hit && !frame_wrap) |=> $stable(line_start));
  // R3
  latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_hit && !frame_wrap) |=> (line_start == $past(ma)));
  // R5
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (ma == $past(base) && line_start == $past(base)));
endmodule

// File: rtl/crtc_raster_gen.sv
module crtc_raster_gen
  import crtc_pkg::*;
#(
  parameter bit SYNC_QUIRK = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_we,
  input  logic [IXW-1:0] sel_data,
  input  logic           dat_we,
  input  logic [7:0]     dat_data,
  output logic [MAW-1:0] mem_addr,
  output logic [RAW-1:0] row_addr,
  output logic           disp_en,
  output logic           hsync,
  output logic           vsync
);
  localparam logic [MAW-1:0] RST_BASE = MAW'(14'h3000);

  crtc_cfg_t      cfg;
  logic           sync_ovr;
  logic [HCW-1:0] hcnt;
  logic           h_wrap, h_act, v_act;
  logic [VRW-1:0] vrow;
  logic           row_end, frame_wrap, latch_hit;
  logic [MAW-1:0] line_start;

  crtc_regfile #(.RST_BASE(RST_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_data(sel_data),
    .dat_we(dat_we), .dat_data(dat_data), .cfg(cfg), .sync_ovr(sync_ovr)
  );

  crtc_hcount #(.SYNC_QUIRK(SYNC_QUIRK)) u_h (
    .clk(clk), .rst_n(rst_n), .h_total(cfg.h_total), .h_disp(cfg.h_disp),
    .hs_pos(cfg.hs_pos), .hs_wid(cfg.hs_wid), .sync_ovr(sync_ovr),
    .hcnt(hcnt), .h_wrap(h_wrap), .h_act(h_act), .hsync(hsync)
  );

  crtc_vcount u_v (
    .clk(clk), .rst_n(rst_n), .h_wrap(h_wrap), .ras_max(cfg.ras_max),
    .v_total(cfg.v_total), .v_disp(cfg.v_disp), .vs_row(cfg.vs_row),
    .vs_wid(cfg.vs_wid), .rcnt(row_addr), .vrow(vrow), .row_end(row_end),
    .frame_wrap(frame_wrap), .v_act(v_act), .vsync(vsync)
  );

  assign latch_hit = (hcnt == cfg.h_disp) && row_end;

  crtc_addr_gen #(.RST_BASE(RST_BASE)) u_a (
    .clk(clk), .rst_n(rst_n), .h_wrap(h_wrap), .latch_hit(latch_hit),
    .frame_wrap(frame_wrap), .base(cfg.base), .ma(mem_addr),
    .line_start(line_start)
  );

  assign disp_en = h_act && v_act;

  // R8
  quirk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SYNC_QUIRK && sync_ovr) |-> !hsync);
  // R10
  disp_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (vrow < cfg.v_disp));
endmodule

// File: tb/sim_crtc_raster_gen.sv
module sim_crtc_raster_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 1'b0, dat_we = 1'b0;
  logic [4:0] sel_data = '0;
  logic [7:0] dat_data = '0;
  logic [13:0] ma0, ma1;
  logic [4:0]  ra0, ra1;
  logic de0, de1, hs0, hs1, vs0, vs1;

  always #2.5 clk = ~clk;

  crtc_raster_gen #(.SYNC_QUIRK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_data(sel_data),
    .dat_we(dat_we), .dat_data(dat_data), .mem_addr(ma0), .row_addr(ra0),
    .disp_en(de0), .hsync(hs0), .vsync(vs0));
  crtc_raster_gen #(.SYNC_QUIRK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_data(sel_data),
    .dat_we(dat_we), .dat_data(dat_data), .mem_addr(ma1), .row_addr(ra1),
    .disp_en(de1), .hsync(hs1), .vsync(vs1));

  int vectors = 0, fails = 0;
  bit running = 0, done = 0;
  string phase = "R12 reset";

  // reference model state
  int rg [0:31];
  int m_h = 0, m_r = 0, m_v = 0, m_ma = 'h3000, m_lat = 'h3000, m_sel = 0;

  function automatic int msk(int idx, int v);
    case (idx)
      4, 6, 7: return v & 127;
      9:       return v & 31;
      12:      return v & 63;
      default: return v & 255;
    endcase
  endfunction

  task automatic model_reset();
    foreach (rg[i]) rg[i] = 0;
    rg[0] = 63; rg[1] = 40; rg[2] = 46; rg[3] = 'h8E; rg[4] = 38;
    rg[6] = 25; rg[7] = 30; rg[9] = 7; rg[12] = 'h30; rg[13] = 0;
    m_h = 0; m_r = 0; m_v = 0; m_ma = 'h3000; m_lat = 'h3000; m_sel = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit hit, frame;
      int nl;
      hit = (m_h == rg[1]) && (m_r == rg[9]);
      nl = hit ? m_ma : m_lat;
      frame = 0;
      if (m_h == rg[0]) begin
        m_h = 0;
        if (m_r == rg[9]) begin
          m_r = 0;
          if (m_v == rg[4]) begin m_v = 0; frame = 1; end
          else m_v = (m_v + 1) & 127;
        end else m_r = (m_r + 1) & 31;
        m_ma = nl;
      end else begin
        m_h = (m_h + 1) & 255;
        m_ma = (m_ma + 1) & 16383;
      end
      m_lat = nl;
      if (frame) begin
        m_ma = (rg[12] << 8) | rg[13];
        m_lat = m_ma;
      end
      if (dat_we) begin
        if (m_sel inside {0,1,2,3,4,6,7,9,12,13}) rg[m_sel] = msk(m_sel, dat_data);
      end
      if (sel_we) m_sel = sel_data;
      running = 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", what, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n && !done) begin
      int hw, vw, lines;
      bit e_de, e_win, e_ovr, e_vs;
      hw = rg[3] & 15;
      vw = ((rg[3] >> 4) == 0) ? 16 : (rg[3] >> 4);
      e_de = (m_h < rg[1]) && (m_v < rg[6]);
      e_win = (m_h >= rg[2]) && (m_h < rg[2] + hw);
      e_ovr = (rg[2] + hw) > rg[0];
      lines = (m_v - rg[7]) * (rg[9] + 1) + m_r;
      e_vs = (m_v >= rg[7]) && (lines < vw);
      chk("R1 R3 R4 R5 R6 mem_addr u0", ma0, m_ma);
      chk("R1 R3 R4 R5 R6 mem_addr u1", ma1, m_ma);
      chk("R2 R4 row_addr", ra0, m_r);
      chk("R10 disp_en", de0, e_de);
      chk("R7 R8 hsync quirk", hs0, e_win && !e_ovr);
      chk("R7 R8 hsync plain", hs1, e_win);
      chk("R9 vsync", vs0, e_vs);
      chk("R9 vsync u1", vs1, e_vs);
    end
  end

  task automatic wr(int idx, int val);
    @(negedge clk); sel_we = 1; sel_data = 5'(idx);
    @(negedge clk); sel_we = 0; dat_we = 1; dat_data = 8'(val);
    @(negedge clk); dat_we = 0;
  endtask

  task automatic small_geometry();
    wr(0, 9); wr(1, 6); wr(2, 7); wr(3, 'h32); wr(4, 4);
    wr(6, 3); wr(7, 3); wr(9, 2); wr(12, 'h01); wr(13, 'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset values visible at the ports while reset is held
    chk("R12 reset mem_addr", ma0, 'h3000);
    chk("R12 reset row_addr", ra0, 0);
    chk("R12 reset disp_en", de0, 1);
    rst_n = 1;
    phase = "R12 default geometry";
    repeat (1200) @(negedge clk);

    phase = "R2 R3 R4 R5 small geometry";
    small_geometry();
    repeat (600) @(negedge clk);

    phase = "R8 sync overrun";
    wr(2, 8); wr(3, 'h33);
    repeat (300) @(negedge clk);

    phase = "R7 zero hsync width, R9 vsync width 16";
    wr(2, 3); wr(3, 'h00);
    repeat (400) @(negedge clk);

    phase = "R6 displayed width beyond line";
    wr(3, 'h32); wr(1, 12);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (m_h == 0 && m_v != 0) chk("R6 row start repeats", ma0, 'h0120);
    end

    phase = "R3 R4 latch on wrap clock";
    wr(1, 9);
    repeat (400) @(negedge clk);

    phase = "R11 unmapped index writes";
    wr(5, 'hFF); wr(8, 'h55); wr(14, 'hAA); wr(31, 3);
    repeat (300) @(negedge clk);
    chk("R11 line length unchanged", rg[0], 9);

    phase = "R11 select then back-to-back data";
    @(negedge clk); sel_we = 1; sel_data = 5'd1;
    @(negedge clk); sel_we = 0; dat_we = 1; dat_data = 8'd4;
    @(negedge clk); dat_data = 8'd5;
    @(negedge clk); dat_we = 0;
    repeat (300) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule